// File: doc/BRIEF.md
# SDRAM Command and Address Decoder

This block sits on the device side of a single-data-rate synchronous DRAM interface. On every rising clock edge it samples the chip-select, row-strobe, column-strobe and write-enable pins, together with the bank and address pins. From these it produces a registered, decoded command. It keeps a per-bank record of which row is open in each of four banks. It reports the auto-precharge request carried on reads and writes, and whether a precharge closes one bank or all of them. Address bit 10 carries both of these meanings. Which one applies depends on the command.

The block also turns the data-mask pins into per-lane controls. A write lane enable follows the mask sampled on the same edge. A read output enable follows the mask with a delay of two further edges. The column address is assembled from a different set of address bits for each data width, and the width is chosen by the `DATA_W` parameter. The clock-enable pin acts as a plain qualifier: while it is sampled low, the clock counts as suspended.

The interface carries no streaming data. Every pin is a plain control or status signal, so there is no valid/ready handshake and no back-pressure.

Top module: `sdc_cmd_decoder`

## Requirements
- R1: With `cke` high and `cs_n` low, the pins {`ras_n`,`cas_n`,`we_n`} decode as follows: 111 is NOP (code 0), 011 is ACTIVE (1), 101 is READ (2), 100 is WRITE (3), 010 is PRECHARGE (4), 001 is AUTO REFRESH (5) and 000 is LOAD MODE (6). The pattern 110 reports NOP. `cmd_code` shows the decoded command after the edge that sampled it.
- R2: A sampled-high `cs_n` reports NOP with `cmd_err` low. It leaves the bank state and `mode_reg` unchanged.
- R3: A sampled-low `cke` reports NOP and clears `cmd_err`, `cmd_autopre` and `cmd_pre_all`. It holds the bank state, `mode_reg`, `wr_lane_en` and `rd_lane_oe`, and it does not advance the read-mask delay.
- R4: ACTIVE to a closed bank `ba` opens it. It stores `addr` in `open_rows[13*ba+12 : 13*ba]`, which keeps the last row after the bank closes. ACTIVE to an open bank sets `cmd_err`, reports NOP and changes nothing.
- R5: READ or WRITE to a closed bank sets `cmd_err`, reports NOP and changes nothing.
- R6: An accepted READ or WRITE reports `cmd_col`. For `DATA_W`=16 it is `addr[9:0]`. For 8 it is {`addr[11]`,`addr[9:0]`}. For 4 it is {`addr[12]`,`addr[11]`,`addr[9:0]`}.
- R7: An accepted READ or WRITE with `addr[10]` high sets `cmd_autopre` and closes that bank.
- R8: PRECHARGE with `addr[10]` high closes every bank and sets `cmd_pre_all`. With `addr[10]` low it closes only bank `ba`.
- R9: LOAD MODE stores `addr` in `mode_reg`.
- R10: `wr_lane_en` is the inverse of the lane mask sampled on the same edge.
- R11: `rd_lane_oe` is the inverse of the lane mask sampled two `cke`-high edges earlier.
- R12: For `DATA_W`=16, lane 0 follows `dqm[0]` and lane 1 follows `dqm[1]`. For 8 and 4 there is a single lane, and it follows `dqm[1]`.
- R13: After reset every bank is closed, `open_rows` and `mode_reg` are zero, `cmd_code` is NOP, all flags are low, and both lane controls are all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock-enable qualifier |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | 13 | Row, column, flag or opcode bits |
| dqm | input | 2 | Data mask pins |
| cmd_code | output | 3 | Decoded command code |
| cmd_bank | output | 2 | Bank of the last sampled command |
| cmd_row | output | 13 | Address sampled with the last command |
| cmd_col | output | 10/11/12 | Column for the configured width |
| cmd_autopre | output | 1 | Accepted read/write requested auto-precharge |
| cmd_pre_all | output | 1 | Precharge targeted all banks |
| cmd_err | output | 1 | Command rejected against bank state |
| bank_open | output | 4 | One bit per bank, high when a row is open |
| open_rows | output | 52 | Row per bank, 13 bits each |
| mode_reg | output | 13 | Stored mode opcode |
| wr_lane_en | output | 1/2 | Write data lane enable |
| rd_lane_oe | output | 1/2 | Read output lane enable |

## Verification
The hardest case to reach is the read-mask delay running while the clock is suspended. A mask value has been sampled, and `cke` goes low before that value reaches `rd_lane_oe`. A second hard case is auto-precharge landing on a bank whose row was set only a few commands earlier. A long pseudo-random sweep drives `cke` low about one cycle in sixteen, draws every pin pattern and bank with equal weight, and shares one stimulus across the three data widths. An independent model written from the requirements follows bank state and the mask delay. Short directed sequences come first and reach the error, all-bank and opcode paths on purpose.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5,
    CMD_LMR = 3'd6
  } cmd_e;

  // Column width for a given data width.
  function automatic int col_width(input int data_w);
    if (data_w == 16) return 10;
    else if (data_w == 8) return 11;
    else return 12;
  endfunction

  // Number of independently masked byte lanes.
  function automatic int lane_count(input int data_w);
    return (data_w == 16) ? 2 : 1;
  endfunction

endpackage

// File: rtl/sdc_cmd_decode.sv
module sdc_cmd_decode
  import sdc_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);

  always_comb begin
    if (cs_n) begin
      cmd = CMD_NOP;
    end else begin
      unique case ({ras_n, cas_n, we_n})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = CMD_REF;
        3'b000:  cmd = CMD_LMR;
        default: cmd = CMD_NOP;
      endcase
    end
  end

endmodule

// File: rtl/sdc_bank_tracker.sv
module sdc_bank_tracker
  import sdc_pkg::*;
#(
  parameter  int NUM_BANKS = 4,
  parameter  int ROW_W     = 13,
  localparam int BA_W      = $clog2(NUM_BANKS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         step,
  input  cmd_e                         cmd,
  input  logic [BA_W-1:0]              ba,
  input  logic [ROW_W-1:0]             row,
  input  logic                         ap,
  output logic                         reject,
  output logic [NUM_BANKS-1:0]         open_q,
  output logic [NUM_BANKS*ROW_W-1:0]   rows_q
);

  logic sel_open;
  assign sel_open = open_q[ba];

  always_comb begin
    unique case (cmd)
      CMD_ACT:        reject = sel_open;
      CMD_RD, CMD_WR: reject = !sel_open;
      default:        reject = 1'b0;
    endcase
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic             hit;
    logic             open_b;
    logic [ROW_W-1:0] row_b;

    assign hit = (ba == BA_W'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_b <= 1'b0;
        row_b  <= '0;
      end else if (step) begin
        unique case (cmd)
          CMD_ACT: begin
            if (hit && !open_b) begin
              open_b <= 1'b1;
              row_b  <= row;
            end
          end
          CMD_RD, CMD_WR: begin
            if (hit && open_b && ap) open_b <= 1'b0;
          end
          CMD_PRE: begin
            if (ap || hit) open_b <= 1'b0;
          end
          default: ;
        endcase
      end
    end

    assign open_q[b]                = open_b;
    assign rows_q[b*ROW_W +: ROW_W] = row_b;
  end

endmodule

// File: rtl/sdc_mask_pipe.sv
module sdc_mask_pipe #(
  parameter int LANES  = 2,
  parameter int RD_LAT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [LANES-1:0] mask,
  output logic [LANES-1:0] wr_en,
  output logic [LANES-1:0] rd_oe
);

  logic [LANES-1:0] stage_q [RD_LAT+1];

  // Stage 0 captures the enable on the sampling edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    stage_q[0] <= '1;
    else if (step) stage_q[0] <= ~mask;
  end

  for (genvar i = 1; i <= RD_LAT; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    stage_q[i] <= '1;
      else if (step) stage_q[i] <= stage_q[i-1];
    end
  end

  assign wr_en = stage_q[0];
  assign rd_oe = stage_q[RD_LAT];

endmodule

// File: rtl/sdc_cmd_decoder.sv
module sdc_cmd_decoder
  import sdc_pkg::*;
#(
  parameter  int DATA_W      = 16,
  parameter  int NUM_BANKS   = 4,
  parameter  int ADDR_W      = 13,
  parameter  int AP_BIT      = 10,
  parameter  int RD_MASK_LAT = 2,
  localparam int BA_W        = $clog2(NUM_BANKS),
  localparam int COL_W       = col_width(DATA_W),
  localparam int LANES       = lane_count(DATA_W)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cke,
  input  logic                        cs_n,
  input  logic                        ras_n,
  input  logic                        cas_n,
  input  logic                        we_n,
  input  logic [BA_W-1:0]             ba,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [1:0]                  dqm,
  output logic [2:0]                  cmd_code,
  output logic [BA_W-1:0]             cmd_bank,
  output logic [ADDR_W-1:0]           cmd_row,
  output logic [COL_W-1:0]            cmd_col,
  output logic                        cmd_autopre,
  output logic                        cmd_pre_all,
  output logic                        cmd_err,
  output logic [NUM_BANKS-1:0]        bank_open,
  output logic [NUM_BANKS*ADDR_W-1:0] open_rows,
  output logic [ADDR_W-1:0]           mode_reg,
  output logic [LANES-1:0]            wr_lane_en,
  output logic [LANES-1:0]            rd_lane_oe
);

  cmd_e             raw_cmd;
  cmd_e             cmd_q;
  logic             reject;
  logic             ap;
  logic             is_rw;
  logic [COL_W-1:0] col_w;
  logic [LANES-1:0] lane_mask;

  assign ap    = addr[AP_BIT];
  assign is_rw = (raw_cmd == CMD_RD) || (raw_cmd == CMD_WR);

  sdc_cmd_decode u_decode (
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cmd   (raw_cmd)
  );

  sdc_bank_tracker #(
    .NUM_BANKS (NUM_BANKS),
    .ROW_W     (ADDR_W)
  ) u_banks (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (cke),
    .cmd    (raw_cmd),
    .ba     (ba),
    .row    (addr),
    .ap     (ap),
    .reject (reject),
    .open_q (bank_open),
    .rows_q (open_rows)
  );

  // Column assembly: the flag bit is skipped, upper bits widen it.
  if (DATA_W == 16) begin : g_col16
    assign col_w = addr[9:0];
  end else if (DATA_W == 8) begin : g_col8
    assign col_w = {addr[11], addr[9:0]};
  end else begin : g_col4
    assign col_w = {addr[12], addr[11], addr[9:0]};
  end

  // Lane mapping: narrow widths use the upper mask pin only.
  if (LANES == 2) begin : g_lane2
    assign lane_mask = dqm;
  end else begin : g_lane1
    assign lane_mask = dqm[1];
  end

  sdc_mask_pipe #(
    .LANES  (LANES),
    .RD_LAT (RD_MASK_LAT)
  ) u_mask (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (cke),
    .mask  (lane_mask),
    .wr_en (wr_lane_en),
    .rd_oe (rd_lane_oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q       <= CMD_NOP;
      cmd_bank    <= '0;
      cmd_row     <= '0;
      cmd_col     <= '0;
      cmd_autopre <= 1'b0;
      cmd_pre_all <= 1'b0;
      cmd_err     <= 1'b0;
      mode_reg    <= '0;
    end else if (cke) begin
      cmd_q       <= reject ? CMD_NOP : raw_cmd;
      cmd_err     <= reject;
      cmd_bank    <= ba;
      cmd_row     <= addr;
      cmd_col     <= col_w;
      cmd_autopre <= is_rw && !reject && ap;
      cmd_pre_all <= (raw_cmd == CMD_PRE) && ap;
      if (raw_cmd == CMD_LMR) mode_reg <= addr;
    end else begin
      cmd_q       <= CMD_NOP;
      cmd_err     <= 1'b0;
      cmd_autopre <= 1'b0;
      cmd_pre_all <= 1'b0;
    end
  end

  assign cmd_code = cmd_q;

endmodule

// File: rtl/sdc_cmd_decoder_chk.sv
module sdc_cmd_decoder_chk
  import sdc_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 13,
  parameter int BA_W      = 2,
  parameter int LANES     = 2
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        cke,
  input logic                        cs_n,
  input logic                        ras_n,
  input logic                        cas_n,
  input logic                        we_n,
  input logic [ADDR_W-1:0]           addr,
  input logic [1:0]                  dqm,
  input logic [2:0]                  cmd_code,
  input logic [BA_W-1:0]             cmd_bank,
  input logic                        cmd_autopre,
  input logic                        cmd_pre_all,
  input logic                        cmd_err,
  input logic [NUM_BANKS-1:0]        bank_open,
  input logic [NUM_BANKS*ADDR_W-1:0] open_rows,
  input logic [ADDR_W-1:0]           mode_reg,
  input logic [LANES-1:0]            wr_lane_en,
  input logic [LANES-1:0]            rd_lane_oe
);

  logic [LANES-1:0] exp_lane;
  if (LANES == 2) begin : g_l2
    assign exp_lane = ~dqm;
  end else begin : g_l1
    assign exp_lane = ~dqm[1];
  end

  a_r2_cs_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && cs_n) |=> (cmd_code == 3'(CMD_NOP) && !cmd_err
                       && $stable(bank_open) && $stable(mode_reg)));

  a_r3_suspend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> (cmd_code == 3'(CMD_NOP) && $stable(bank_open) && $stable(open_rows)
              && $stable(wr_lane_en) && $stable(rd_lane_oe)));

  a_r4_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == 3'(CMD_ACT)) |-> bank_open[cmd_bank]);

  a_r5_err_is_nop: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> (cmd_code == 3'(CMD_NOP)));

  a_r7_autopre_closes: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_autopre |-> ((cmd_code == 3'(CMD_RD) || cmd_code == 3'(CMD_WR))
                     && !bank_open[cmd_bank]));

  a_r8_pre_all: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == 3'(CMD_PRE) && cmd_pre_all) |-> (bank_open == '0));

  a_r8_pre_one: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == 3'(CMD_PRE)) |-> !bank_open[cmd_bank]);

  a_r9_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && !cs_n && !ras_n && !cas_n && !we_n) |=> (mode_reg == $past(addr)));

  a_r10_wr_mask: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> (wr_lane_en == $past(exp_lane)));

endmodule

bind sdc_cmd_decoder sdc_cmd_decoder_chk #(
  .NUM_BANKS (NUM_BANKS),
  .ADDR_W    (ADDR_W),
  .BA_W      (BA_W),
  .LANES     (LANES)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cke         (cke),
  .cs_n        (cs_n),
  .ras_n       (ras_n),
  .cas_n       (cas_n),
  .we_n        (we_n),
  .addr        (addr),
  .dqm         (dqm),
  .cmd_code    (cmd_code),
  .cmd_bank    (cmd_bank),
  .cmd_autopre (cmd_autopre),
  .cmd_pre_all (cmd_pre_all),
  .cmd_err     (cmd_err),
  .bank_open   (bank_open),
  .open_rows   (open_rows),
  .mode_reg    (mode_reg),
  .wr_lane_en  (wr_lane_en),
  .rd_lane_oe  (rd_lane_oe)
);

// File: tb/sdc_cmd_decoder_tb_top.sv
module sdc_cmd_decoder_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int SWEEP_N    = 1500;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [12:0] addr = '0;
  logic [1:0]  dqm = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [2:0]  c16, c8, c4;
  logic [1:0]  b16, b8, b4;
  logic [12:0] r16, r8, r4, m16, m8, m4;
  logic [9:0]  col16;
  logic [10:0] col8;
  logic [11:0] col4;
  logic        ap16, ap8, ap4, pa16, pa8, pa4, e16, e8, e4;
  logic [3:0]  o16, o8, o4;
  logic [51:0] rows16, rows8, rows4;
  logic [1:0]  wr16, oe16;
  logic        wr8, oe8, wr4, oe4;

  sdc_cmd_decoder #(.DATA_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .dqm(dqm), .cmd_code(c16), .cmd_bank(b16),
    .cmd_row(r16), .cmd_col(col16), .cmd_autopre(ap16), .cmd_pre_all(pa16),
    .cmd_err(e16), .bank_open(o16), .open_rows(rows16), .mode_reg(m16),
    .wr_lane_en(wr16), .rd_lane_oe(oe16));

  sdc_cmd_decoder #(.DATA_W(8)) dut8_i (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .dqm(dqm), .cmd_code(c8), .cmd_bank(b8),
    .cmd_row(r8), .cmd_col(col8), .cmd_autopre(ap8), .cmd_pre_all(pa8),
    .cmd_err(e8), .bank_open(o8), .open_rows(rows8), .mode_reg(m8),
    .wr_lane_en(wr8), .rd_lane_oe(oe8));

  sdc_cmd_decoder #(.DATA_W(4)) dut4_i (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .dqm(dqm), .cmd_code(c4), .cmd_bank(b4),
    .cmd_row(r4), .cmd_col(col4), .cmd_autopre(ap4), .cmd_pre_all(pa4),
    .cmd_err(e4), .bank_open(o4), .open_rows(rows4), .mode_reg(m4),
    .wr_lane_en(wr4), .rd_lane_oe(oe4));

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // Reference state, built from the requirements.
  logic [3:0]  m_open;
  logic [12:0] m_row [4];
  logic [12:0] m_mode;
  logic [1:0]  m_en [3];   // enable pipeline: [0] newest

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [2:0] ref_cmd(input logic s, input logic r,
                                         input logic c, input logic w);
    if (s) return 3'd0;
    case ({r, c, w})
      3'b011:  return 3'd1;
      3'b101:  return 3'd2;
      3'b100:  return 3'd3;
      3'b010:  return 3'd4;
      3'b001:  return 3'd5;
      3'b000:  return 3'd6;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [51:0] flat_rows();
    return {m_row[3], m_row[2], m_row[1], m_row[0]};
  endfunction

  // Drive one cycle of pins (at a falling edge), predict, and compare after the edge.
  task automatic apply(input logic k, input logic s, input logic [2:0] rcw,
                       input logic [1:0] b, input logic [12:0] a, input logic [1:0] m);
    logic [2:0] raw, e_code;
    logic       rej, e_err, e_ap, e_pa, rw, a10;
    string      tag;
    cke = k; cs_n = s; {ras_n, cas_n, we_n} = rcw; ba = b; addr = a; dqm = m;
    raw = ref_cmd(s, rcw[2], rcw[1], rcw[0]);
    a10 = a[10];
    rw  = (raw == 3'd2) || (raw == 3'd3);
    rej = (raw == 3'd1 && m_open[b]) || (rw && !m_open[b]);
    tag = !k ? "R3" : (s ? "R2" : "R1");
    if (k) begin
      e_code = rej ? 3'd0 : raw;
      e_err  = rej;
      e_ap   = rw && !rej && a10;
      e_pa   = (raw == 3'd4) && a10;
      if (raw == 3'd1 && !rej) begin m_open[b] = 1'b1; m_row[b] = a; end
      if (rw && !rej && a10) m_open[b] = 1'b0;
      if (raw == 3'd4) begin
        if (a10) m_open = '0; else m_open[b] = 1'b0;
      end
      if (raw == 3'd6) m_mode = a;
      m_en[2] = m_en[1]; m_en[1] = m_en[0]; m_en[0] = ~m;
    end else begin
      e_code = 3'd0; e_err = 1'b0; e_ap = 1'b0; e_pa = 1'b0;
    end
    @(negedge clk);
    check(tag, "cmd_code x16", 64'(c16), 64'(e_code));
    check(tag, "cmd_code x4", 64'(c4), 64'(e_code));
    check(rw ? "R5" : "R4", "cmd_err", 64'(e16), 64'(e_err));
    check(tag, "bank_open", 64'(o16), 64'(m_open));
    check("R4", "open_rows", 64'(rows16), 64'(flat_rows()));
    check("R9", "mode_reg", 64'(m8), 64'(m_mode));
    check("R7", "cmd_autopre", 64'(ap16), 64'(e_ap));
    check("R8", "cmd_pre_all", 64'(pa4), 64'(e_pa));
    check("R10", "wr_lane_en x16", 64'(wr16), 64'(m_en[0]));
    check("R12", "wr_lane_en x8", 64'(wr8), 64'(m_en[0][1]));
    check("R11", "rd_lane_oe x16", 64'(oe16), 64'(m_en[2]));
    check("R12", "rd_lane_oe x4", 64'(oe4), 64'(m_en[2][1]));
    if (k && rw && !rej) begin
      check("R6", "col x16", 64'(col16), 64'(a[9:0]));
      check("R6", "col x8", 64'(col8), 64'({a[11], a[9:0]}));
      check("R6", "col x4", 64'(col4), 64'({a[12:11], a[9:0]}));
    end
    if (k && raw == 3'd1 && !rej) begin
      check("R4", "cmd_row", 64'(r16), 64'(a));
      check("R4", "cmd_bank", 64'(b16), 64'(b));
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 120000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] seed;
    m_open = '0; m_mode = '0;
    for (int i = 0; i < 4; i++) m_row[i] = '0;
    for (int i = 0; i < 3; i++) m_en[i] = 2'b11;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R13: reset state, before any active edge
    check("R13", "cmd_code", 64'(c16), 64'd0);
    check("R13", "bank_open", 64'(o8), 64'd0);
    check("R13", "mode_reg", 64'(m4), 64'd0);
    check("R13", "flags", 64'({e16, ap16, pa16}), 64'd0);
    check("R13", "lane enables", 64'({wr16, oe16}), 64'hF);
    // Directed sequence
    apply(1, 0, 3'b011, 2'd1, 13'h1ABC, 2'b00);  // ACT bank 1
    apply(1, 0, 3'b100, 2'd1, 13'h1BFF, 2'b01);  // WRITE, mask lane 0
    apply(1, 0, 3'b101, 2'd2, 13'h0010, 2'b10);  // READ closed bank: error
    apply(1, 0, 3'b011, 2'd1, 13'h0005, 2'b00);  // ACT open bank: error
    apply(0, 0, 3'b101, 2'd1, 13'h0003, 2'b11);  // suspended clock
    apply(1, 1, 3'b011, 2'd0, 13'h0007, 2'b00);  // chip select high
    apply(1, 0, 3'b101, 2'd1, 13'h0403, 2'b00);  // READ with auto-precharge
    apply(1, 0, 3'b011, 2'd0, 13'h0111, 2'b00);
    apply(1, 0, 3'b011, 2'd3, 13'h1333, 2'b00);
    apply(1, 0, 3'b010, 2'd0, 13'h0000, 2'b00);  // PRE single bank 0
    apply(1, 0, 3'b011, 2'd2, 13'h0222, 2'b00);
    apply(1, 0, 3'b010, 2'd1, 13'h0400, 2'b00);  // PRE all
    apply(1, 0, 3'b000, 2'd0, 13'h0233, 2'b00);  // LOAD MODE
    apply(1, 0, 3'b001, 2'd0, 13'h0000, 2'b00);  // AUTO REFRESH
    apply(1, 0, 3'b110, 2'd0, 13'h0000, 2'b00);  // unlisted pattern
    // Pseudo-random sweep over pins
    seed = 32'h1234_5679;
    for (int it = 0; it < SWEEP_N; it++) begin
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 17);
      seed = seed ^ (seed << 5);
      apply(seed[3:0] != 4'd0, seed[7:4] == 4'd0, seed[10:8], seed[12:11],
            seed[25:13], seed[27:26]);
    end
    finish_run();
  end

endmodule